// File: doc/BRIEF.md
# Pipelined Burst SRAM with Byte-Lane Writes

This block is a synchronous static memory with a registered request stage and a registered read port. On every rising clock edge it captures the address, the three select inputs, the burst and strobe controls, the write controls and the write data. An access starts on one of two start strobes. After that, the block produces the rest of a four-word burst by itself, using a two-bit offset counter on the lowest address bits. The counter steps in either linear or interleaved order and moves forward only when the step input is held low.

Writes act on 9-bit byte lanes. A global write line overrides everything else and writes every lane. Without it, a lane is written only when its own lane enable and the shared lane-write gate are both low.

Read data leaves through an output register. The drive-enable output is gated without any clock by an active-low output enable. A deselect stops the block from driving one cycle after the last read word, so two devices that share a bus never overlap. Memory depth is a parameter, and its default is kept small.

Top module: `burst_sram`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `rd_drive` is 0.
- R2: `start_p_n` = 0, sampled while the chip is selected, starts a read at `addr` whatever the write controls are. When `start_p_n` and `start_c_n` are both low, `start_p_n` wins and memory is left unchanged.
- R3: `start_p_n` = 0, sampled while the chip is not selected, is ignored. If `start_c_n` is high, a burst in progress continues at its current address.
- R4: `start_c_n` = 0 (with `start_p_n` high) loads `addr` and the selects. If selected, the cycle is a write when any lane is enabled and a read otherwise. If not selected, the burst ends and `rd_drive` goes low after the edge that follows the deselect edge.
- R5: The chip is selected only when `sel_n` = 0, `sel_hi` = 1 and `sel_lo_n` = 0.
- R6: With `burst_linear` = 1, sampled at the start strobe, word k of a burst is at address bits [1:0] = start + k mod 4. The upper address bits never change during a burst, even after the offset wraps.
- R7: With `burst_linear` = 0, sampled at the start strobe, word k of a burst is at bits [1:0] = start XOR k.
- R8: In a burst, when no strobe is taken, `step_n` = 0 moves to the next word and `step_n` = 1 repeats the access at the current address.
- R9: `wr_all_n` = 0 writes every lane, whatever `wr_byte_n` and `lane_we_n` are.
- R10: When `wr_all_n` = 1 and `wr_byte_n` = 0, lane i (data bits [9i+8:9i]) is written only if `lane_we_n[i]` = 0, and the other lanes keep their contents. When `wr_all_n` = 1 and `wr_byte_n` = 1, `lane_we_n` is ignored and the cycle is a read.
- R11: A read whose address is sampled at edge k shows the word on `rd_data`, with `rd_drive` = 1, after edge k+1.
- R12: `out_en_n` = 1 forces `rd_drive` to 0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address, loaded on a start strobe |
| start_p_n | input | 1 | Read start strobe, active low, takes priority |
| start_c_n | input | 1 | Read or write start strobe, active low |
| step_n | input | 1 | Burst step, active low |
| sel_n | input | 1 | Active-low select |
| sel_hi | input | 1 | Active-high expansion select |
| sel_lo_n | input | 1 | Active-low expansion select |
| wr_all_n | input | 1 | Global write, all lanes, active low |
| wr_byte_n | input | 1 | Lane-write gate, active low |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| burst_linear | input | 1 | 1 = linear burst order, 0 = interleaved |
| out_en_n | input | 1 | Output enable, active low, not clocked |
| wr_data | input | LANES*LANE_W | Write data |
| rd_data | output | LANES*LANE_W | Registered read data |
| rd_drive | output | 1 | Read data is being driven |

## Verification
Bursts are written and read back from several start offsets, with each start strobe, in both orders. A burst long enough to wrap shows whether the offset counter carries into the upper address bits, and reading a burst in the opposite order to the one used for writing tells linear from interleaved. Hold cycles are set against step cycles to check the step input. Strobe collisions and strobes that arrive while the chip is deselected show the priority and ignore rules. Single-lane writes, a global write with the lane enables off, and a write with the lane gate off separate the three write-control paths. Every read is compared with a model of memory kept by the bench.

// File: rtl/sbr_pkg.sv
`timescale 1ns/1ps
package sbr_pkg;

    localparam int BURST_LEN = 4;
    localparam int OFS_W     = $clog2(BURST_LEN);

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } acc_op_e;

    typedef struct packed {
        logic             active;
        logic             linear;
        logic [OFS_W-1:0] start;
        logic [OFS_W-1:0] count;
    } burst_t;

    // Word offset inside the aligned burst block.
    function automatic logic [OFS_W-1:0] burst_offset(
        input logic [OFS_W-1:0] start,
        input logic [OFS_W-1:0] count,
        input logic             linear
    );
        if (linear)
            return start + count;
        else
            return start ^ count;
    endfunction

    function automatic logic chip_selected(
        input logic en_pipe_n,
        input logic en_hi,
        input logic en_lo_n
    );
        return !en_pipe_n && en_hi && !en_lo_n;
    endfunction

endpackage

// File: rtl/sbr_burst_ctl.sv
`timescale 1ns/1ps
module sbr_burst_ctl
    import sbr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              start_p_n,
    input  logic              start_c_n,
    input  logic              step_n,
    input  logic              sel_n,
    input  logic              sel_hi,
    input  logic              sel_lo_n,
    input  logic              wr_all_n,
    input  logic              wr_byte_n,
    input  logic [LANES-1:0]  lane_we_n,
    input  logic              burst_linear,
    output acc_op_e           acc_op,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [LANES-1:0]  acc_mask
);

    localparam int HI_W = ADDR_W - OFS_W;

    logic [HI_W-1:0]  block_q, block_d;
    burst_t           bst_q, bst_d;
    acc_op_e          op_q, op_d;
    logic [LANES-1:0] mask_q, mask_d, wmask;
    logic             sel_ok, p_take, c_take, any_wr;

    // Lane write decode: global write overrides, otherwise gated lanes.
    always_comb begin
        for (int i = 0; i < LANES; i++)
            wmask[i] = !wr_all_n || (!wr_byte_n && !lane_we_n[i]);
        any_wr = |wmask;
    end

    assign sel_ok = chip_selected(sel_n, sel_hi, sel_lo_n);
    assign p_take = !start_p_n && sel_ok;
    assign c_take = !start_c_n && !p_take;

    always_comb begin
        block_d = block_q;
        bst_d   = bst_q;
        op_d    = OP_IDLE;
        mask_d  = '0;
        if (p_take) begin
            block_d      = addr_in[ADDR_W-1:OFS_W];
            bst_d.active = 1'b1;
            bst_d.linear = burst_linear;
            bst_d.start  = addr_in[OFS_W-1:0];
            bst_d.count  = '0;
            op_d         = OP_READ;
        end else if (c_take) begin
            block_d = addr_in[ADDR_W-1:OFS_W];
            if (sel_ok) begin
                bst_d.active = 1'b1;
                bst_d.linear = burst_linear;
                bst_d.start  = addr_in[OFS_W-1:0];
                bst_d.count  = '0;
                op_d         = any_wr ? OP_WRITE : OP_READ;
                mask_d       = wmask;
            end else begin
                bst_d.active = 1'b0;
            end
        end else if (bst_q.active) begin
            if (!step_n)
                bst_d.count = bst_q.count + 1'b1;
            op_d   = any_wr ? OP_WRITE : OP_READ;
            mask_d = wmask;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            block_q <= '0;
            bst_q   <= '0;
            op_q    <= OP_IDLE;
            mask_q  <= '0;
        end else begin
            block_q <= block_d;
            bst_q   <= bst_d;
            op_q    <= op_d;
            mask_q  <= mask_d;
        end
    end

    assign acc_op   = op_q;
    assign acc_mask = mask_q;
    assign acc_addr = {block_q, burst_offset(bst_q.start, bst_q.count, bst_q.linear)};

    // R8: a hold cycle in a burst keeps the access address.
    a_r8_hold_addr: assert property (@(posedge clk) disable iff (rst)
        (bst_q.active && start_p_n && start_c_n && step_n) |=> $stable(acc_addr));

    // R6: continuation never changes the block bits.
    a_r6_block_fixed: assert property (@(posedge clk) disable iff (rst)
        (bst_q.active && start_p_n && start_c_n)
        |=> (acc_addr[ADDR_W-1:OFS_W] == $past(acc_addr[ADDR_W-1:OFS_W])));

    // R2: a taken processor strobe always yields a read with no lanes.
    a_r2_proc_read: assert property (@(posedge clk) disable iff (rst)
        (!start_p_n && chip_selected(sel_n, sel_hi, sel_lo_n))
        |=> (acc_op == OP_READ && acc_mask == '0));

    // R5: controller strobe while deselected makes no access.
    a_r5_desel_idle: assert property (@(posedge clk) disable iff (rst)
        (!start_c_n && start_p_n && !chip_selected(sel_n, sel_hi, sel_lo_n))
        |=> (acc_op == OP_IDLE));

endmodule

// File: rtl/sbr_lane_array.sv
`timescale 1ns/1ps
module sbr_lane_array
    import sbr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  acc_op_e                 acc_op,
    input  logic [ADDR_W-1:0]       acc_addr,
    input  logic [LANES-1:0]        acc_mask,
    output logic [LANES*LANE_W-1:0] rd_word
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int WORD_W = LANES * LANE_W;

    // Write data is registered on the same edge as its address.
    logic [WORD_W-1:0] wdata_q;

    always_ff @(posedge clk)
        wdata_q <= wr_data;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (acc_op == OP_WRITE && acc_mask[g])
                mem[acc_addr] <= wdata_q[g*LANE_W +: LANE_W];
        end

        assign rd_word[g*LANE_W +: LANE_W] = mem[acc_addr];
    end

endmodule

// File: rtl/sbr_out_stage.sv
`timescale 1ns/1ps
module sbr_out_stage
    import sbr_pkg::*;
#(
    parameter int WORD_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_op_e           acc_op,
    input  logic [WORD_W-1:0] rd_word,
    input  logic              out_en_n,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_drive
);

    logic [WORD_W-1:0] data_q;
    logic              valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= (acc_op == OP_READ);
            if (acc_op == OP_READ)
                data_q <= rd_word;
        end
    end

    assign rd_data  = data_q;
    assign rd_drive = valid_q && !out_en_n;

    // R11: the output register holds what the array returned for the read.
    a_r11_read_word: assert property (@(posedge clk) disable iff (rst)
        (acc_op == OP_READ) |=> (rd_data == $past(rd_word)));

endmodule

// File: rtl/burst_sram.sv
`timescale 1ns/1ps
module burst_sram
    import sbr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    start_p_n,
    input  logic                    start_c_n,
    input  logic                    step_n,
    input  logic                    sel_n,
    input  logic                    sel_hi,
    input  logic                    sel_lo_n,
    input  logic                    wr_all_n,
    input  logic                    wr_byte_n,
    input  logic [LANES-1:0]        lane_we_n,
    input  logic                    burst_linear,
    input  logic                    out_en_n,
    input  logic [LANES*LANE_W-1:0] wr_data,
    output logic [LANES*LANE_W-1:0] rd_data,
    output logic                    rd_drive
);

    localparam int WORD_W = LANES * LANE_W;

    acc_op_e           acc_op;
    logic [ADDR_W-1:0] acc_addr;
    logic [LANES-1:0]  acc_mask;
    logic [WORD_W-1:0] rd_word;

    sbr_burst_ctl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctl (
        .clk          (clk),
        .rst          (rst),
        .addr_in      (addr),
        .start_p_n    (start_p_n),
        .start_c_n    (start_c_n),
        .step_n       (step_n),
        .sel_n        (sel_n),
        .sel_hi       (sel_hi),
        .sel_lo_n     (sel_lo_n),
        .wr_all_n     (wr_all_n),
        .wr_byte_n    (wr_byte_n),
        .lane_we_n    (lane_we_n),
        .burst_linear (burst_linear),
        .acc_op       (acc_op),
        .acc_addr     (acc_addr),
        .acc_mask     (acc_mask)
    );

    sbr_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk      (clk),
        .wr_data  (wr_data),
        .acc_op   (acc_op),
        .acc_addr (acc_addr),
        .acc_mask (acc_mask),
        .rd_word  (rd_word)
    );

    sbr_out_stage #(.WORD_W(WORD_W)) u_out (
        .clk      (clk),
        .rst      (rst),
        .acc_op   (acc_op),
        .rd_word  (rd_word),
        .out_en_n (out_en_n),
        .rd_data  (rd_data),
        .rd_drive (rd_drive)
    );

    // R4: a cycle with no access leaves the bus undriven one edge later.
    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (acc_op == OP_IDLE) |=> !rd_drive);

endmodule

// File: tb/sim_burst_sram.sv
`timescale 1ns/100ps
module sim_burst_sram;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  addr = '0;
    logic        start_p_n, start_c_n, step_n;
    logic        sel_n, sel_hi, sel_lo_n;
    logic        wr_all_n, wr_byte_n;
    logic [1:0]  lane_we_n;
    logic        burst_linear = 1'b1;
    logic        out_en_n;
    logic [17:0] wr_data = '0;
    logic [17:0] rd_data;
    logic        rd_drive;

    burst_sram u0 (
        .clk(clk), .rst(rst), .addr(addr),
        .start_p_n(start_p_n), .start_c_n(start_c_n), .step_n(step_n),
        .sel_n(sel_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
        .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_we_n(lane_we_n),
        .burst_linear(burst_linear), .out_en_n(out_en_n),
        .wr_data(wr_data), .rd_data(rd_data), .rd_drive(rd_drive)
    );

    always #2 clk = ~clk;

    typedef struct {
        int          due;
        logic        drv;
        logic [17:0] data;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    exp_t        e;
    int          cyc = 0;
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;
    logic [17:0] model_mem [256];

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare each expected output in the cycle it is due.
    always @(negedge clk) begin
        while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
            e = exp_q.pop_front();
            checks++;
            if (rd_drive !== e.drv || (e.drv && rd_data !== e.data)) begin
                errors++;
                $display("FAIL %s: drive=%0b data=%h expected drive=%0b data=%h",
                         e.tag, rd_drive, rd_data, e.drv, e.data);
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic act, input logic expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, expv);
        end
    endtask

    function automatic logic [7:0] ba(input logic [7:0] b, input int k, input bit lin);
        logic [1:0] kk;
        kk = k[1:0];
        return {b[7:2], lin ? (b[1:0] + kk) : (b[1:0] ^ kk)};
    endfunction

    function automatic void model_wr(input logic [7:0] a, input logic [17:0] d,
                                     input logic all_n, input logic byte_n,
                                     input logic [1:0] lwe);
        for (int i = 0; i < 2; i++)
            if (!all_n || (!byte_n && !lwe[i]))
                model_mem[a][i*9 +: 9] = d[i*9 +: 9];
    endfunction

    task automatic idle_inputs();
        start_p_n = 1; start_c_n = 1; step_n = 1;
        sel_n = 0; sel_hi = 1; sel_lo_n = 0;
        wr_all_n = 1; wr_byte_n = 1; lane_we_n = 2'b11; out_en_n = 0;
    endtask

    // Driver step: record the expectation due after the next two edges.
    task automatic t_cycle(input logic drv, input logic [17:0] d, input string tag);
        exp_t x;
        x.due = cyc + 2; x.drv = drv; x.data = d; x.tag = tag;
        exp_q.push_back(x);
        @(posedge clk);
        #1;
    endtask

    task automatic desel(input string tag);
        idle_inputs();
        start_c_n = 0; sel_n = 1;
        t_cycle(0, '0, tag);
    endtask

    task automatic burst_wr(input logic [7:0] base, input bit lin,
                            input logic [17:0] seed, input string tag);
        for (int k = 0; k < 4; k++) begin
            idle_inputs();
            burst_linear = lin;
            if (k == 0) start_c_n = 0; else step_n = 0;
            addr = base;
            wr_all_n = 0;
            wr_data = seed + 18'(k * 18'h00111);
            model_wr(ba(base, k, lin), wr_data, 0, 1, 2'b11);
            t_cycle(0, '0, tag);
        end
    endtask

    task automatic burst_rd(input logic [7:0] base, input bit lin, input bit use_p,
                            input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            idle_inputs();
            burst_linear = lin;
            if (k == 0) begin
                if (use_p) start_p_n = 0; else start_c_n = 0;
            end else begin
                step_n = 0;
            end
            addr = base;
            t_cycle(1, model_mem[ba(base, k, lin)], tag);
        end
    endtask

    task automatic read1(input logic [7:0] a, input bit use_p, input string tag);
        idle_inputs();
        if (use_p) start_p_n = 0; else start_c_n = 0;
        addr = a;
        t_cycle(1, model_mem[a], tag);
    endtask

    task automatic write1(input logic [7:0] a, input logic [17:0] d, input logic all_n,
                          input logic byte_n, input logic [1:0] lwe, input string tag);
        idle_inputs();
        start_c_n = 0; addr = a; wr_data = d;
        wr_all_n = all_n; wr_byte_n = byte_n; lane_we_n = lwe;
        model_wr(a, d, all_n, byte_n, lwe);
        t_cycle(0, '0, tag);
    endtask

    initial begin
        idle_inputs();
        repeat (3) @(posedge clk);
        #1;
        chk(rd_drive == 1'b0, "R1 drive during reset", rd_drive, 1'b0);
        rst = 0;
        @(posedge clk);
        #1;
        chk(rd_drive == 1'b0, "R1 drive after reset", rd_drive, 1'b0);

        // Fill three blocks with global-write bursts.
        burst_wr(8'h10, 1, 18'h00101, "R9 linear write burst");
        burst_wr(8'h22, 0, 18'h10203, "R7 interleaved write burst");
        burst_wr(8'h51, 1, 18'h20305, "R6 linear write burst");
        desel("R4 after writes");

        // Read back in each order and with each strobe.
        burst_rd(8'h11, 1, 1, 4, "R6 linear read");
        desel("R4 deselect after linear read");
        burst_rd(8'h23, 0, 0, 4, "R7 interleaved read");
        desel("R4 deselect after interleaved read");
        burst_rd(8'h52, 0, 1, 4, "R7 cross-order read");
        burst_rd(8'h13, 1, 1, 5, "R6 wrap without carry");
        desel("R4 deselect after wrap");

        // Hold versus step.
        read1(8'h12, 1, "R11 single read");
        idle_inputs();
        t_cycle(1, model_mem[8'h12], "R8 hold 1");
        t_cycle(1, model_mem[8'h12], "R8 hold 2");
        step_n = 0;
        t_cycle(1, model_mem[8'h13], "R8 step");
        desel("R4 deselect after hold");

        // Processor strobe while deselected is ignored.
        read1(8'h50, 1, "R3 burst start");
        idle_inputs();
        start_p_n = 0; sel_n = 1; addr = 8'h20;
        t_cycle(1, model_mem[8'h50], "R3 ignored strobe keeps burst");
        desel("R4 deselect after R3");

        // Select decode.
        idle_inputs();
        start_c_n = 0; sel_hi = 0; addr = 8'h50;
        t_cycle(0, '0, "R5 sel_hi low");
        idle_inputs();
        start_p_n = 0; sel_lo_n = 1; addr = 8'h50;
        t_cycle(0, '0, "R5 sel_lo_n high");
        idle_inputs();
        t_cycle(0, '0, "R5 no burst active");
        read1(8'h50, 1, "R5 all selects active");
        desel("R4 deselect after R5");

        // Lane writes.
        write1(8'h40, 18'h15555, 0, 1, 2'b11, "R9 full write");
        write1(8'h40, 18'h000F0, 1, 0, 2'b10, "R10 lane0 only");
        write1(8'h40, 18'h3FE00, 1, 0, 2'b01, "R10 lane1 only");
        desel("R4");
        read1(8'h40, 0, "R10 merged lanes");
        idle_inputs();
        start_c_n = 0; addr = 8'h40; wr_data = 18'h2AAAA; lane_we_n = 2'b00;
        t_cycle(1, model_mem[8'h40], "R10 gate off is read");
        read1(8'h40, 1, "R10 unchanged after gated-off cycle");
        write1(8'h40, 18'h0ABCD, 0, 1, 2'b11, "R9 global overrides lanes");
        desel("R4");
        read1(8'h40, 1, "R9 global write result");

        // Strobe collision with writes requested.
        idle_inputs();
        start_p_n = 0; start_c_n = 0; addr = 8'h40;
        wr_all_n = 0; wr_data = 18'h33333;
        t_cycle(1, model_mem[8'h40], "R2 collision reads");
        desel("R4");
        read1(8'h40, 1, "R2 memory unchanged");

        // Output enable acts without a clock.
        read1(8'h22, 1, "R11 read for R12");
        idle_inputs();
        t_cycle(1, model_mem[8'h22], "R12 hold");
        @(negedge clk);
        #0.5 out_en_n = 1;
        #0.5 chk(rd_drive == 1'b0, "R12 off without clock", rd_drive, 1'b0);
        out_en_n = 0;
        #0.3 chk(rd_drive == 1'b1, "R12 back on without clock", rd_drive, 1'b1);
        desel("R4 final deselect");
        idle_inputs();
        sel_n = 1;
        repeat (4) @(posedge clk);
        #1;
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule